// File: doc/BRIEF.md
# Multi-voice additive audio synthesizer

This block makes stereo audio by adding up 64 tone generators. Each generator (a voice) is set by one 32-bit control word. The word gives a frequency in quarter-hertz steps, a choice between a sine tone and white noise, and two 8-bit loudness values, one for the left channel and one for the right. A single arithmetic path serves all voices in turn. It reads a voice's control word, phase and noise state, weights the wave value by the two loudness values, adds the products to two running sums, and writes back the advanced phase.

A pulse on `tick` marks one audio sample period. After the pulse the block visits every voice once. It then adds the two signed 16-bit direct sample inputs to the sums, clamps each channel to the signed 12-bit range, and presents the result with a one-cycle valid strobe. The outputs hold their value until the next strobe. The control words are loaded through a simple write port. With the default 20-bit phase, one phase step is one quarter-hertz when the sample rate is 2^18 Hz.

Top module: `voice_synth`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_l` and `out_r` are 0. Every control word is 0, every phase is 0, and every noise register holds 16'hACE1.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored as the control word of voice `wr_addr`. Bits 14:0 are the phase increment, bit 15 selects noise (1) or sine (0), bits 23:16 are the left loudness and bits 31:24 are the right loudness.
- R3: Suppose `tick` is sampled high while `busy` is low at clock edge k. Then `busy` is high after edges k through k+63. After edge k+64, `busy` is low and `out_valid` is high for exactly one cycle.
- R4: A `tick` sampled while `busy` is high has no effect. The strobe still arrives on time, and every phase advances once per sweep.
- R5: Voice v's wave value is taken from its phase before the update. The phase then advances by bits 14:0 of its word, modulo 2^20. The wave index k is the top 6 phase bits.
- R6: The sine wave value for index k is round(127*sin(2*pi*(k+0.5)/64)), a signed value in -127..127.
- R7: The noise wave value is bits 15:8 of the voice's noise register, read as signed. The register shifts left by one, taking in the XOR of its bits 15, 13, 12 and 10, only on a sweep in which the phase addition carries out of bit 19.
- R8: Each channel output is floor(sum of wave*loudness / 16) + floor(sample / 16). The result is clamped to -2048..2047 and given as 12-bit two's complement.
- R9: If the loudness values of one channel sum to 255 or less and that channel's sample input is 0, the channel never reaches the clamp.
- R10: `out_l` and `out_r` change only in the cycle in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-period pulse that starts a sweep |
| wr_en | input | 1 | Control word write enable |
| wr_addr | input | 6 | Voice number to write |
| wr_data | input | 32 | Control word |
| smp_l | input | 16 | Signed direct sample, left |
| smp_r | input | 16 | Signed direct sample, right |
| busy | output | 1 | Sweep in progress |
| out_valid | output | 1 | One-cycle strobe when new outputs appear |
| out_l | output | 12 | Left channel, signed |
| out_r | output | 12 | Right channel, signed |

## Verification
Assertions check the sweep sequencing on every cycle: that it starts only from a tick, that the voice index steps through without a pause, that a late tick is ignored, that the strobe is a single pulse at the end of a sweep, and that the outputs hold between strobes. The numeric content cannot be seen by a property. This covers the sine table values, the noise register steps at phase wrap, the weighting, the floor division and the clamping at both rails. Only the bench scenarios show these, by comparing each strobe against a model of the phases and noise registers kept over many sweeps.

// File: rtl/voice_synth.sv
module voice_synth #(
  parameter int NVOICE = 64,
  parameter int PHASE_W = 20,
  parameter int OUT_W = 12,
  parameter int SMP_W = 16,
  parameter int FRAC_SH = 4,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       wr_en,
  input  logic [$clog2(NVOICE)-1:0]  wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [SMP_W-1:0]           smp_l,
  input  logic [SMP_W-1:0]           smp_r,
  output logic                       busy,
  output logic                       out_valid,
  output logic [OUT_W-1:0]           out_l,
  output logic [OUT_W-1:0]           out_r
);
  localparam int IDX_W = $clog2(NVOICE);
  localparam int AMP_W = 8;
  localparam int ACC_W = 8 + AMP_W + IDX_W + 1;
  localparam int MIX_W = ACC_W + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NVOICE - 1);
  localparam logic signed [MIX_W-1:0] HI = MIX_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [MIX_W-1:0] LO = ~HI;

  logic [31:0]        voice_q [NVOICE];
  logic [PHASE_W-1:0] phase_q [NVOICE];
  logic [15:0]        lfsr_q  [NVOICE];
  logic [IDX_W-1:0]   idx_q;
  logic signed [ACC_W-1:0] acc_l_q, acc_r_q;

  wire [31:0]        cur    = voice_q[idx_q];
  wire [PHASE_W-1:0] cur_ph = phase_q[idx_q];
  wire [15:0]        cur_lf = lfsr_q[idx_q];
  wire [PHASE_W:0]   ph_sum = {1'b0, cur_ph} + {{(PHASE_W - 14){1'b0}}, cur[14:0]};
  wire [15:0]        lf_step = {cur_lf[14:0], cur_lf[15] ^ cur_lf[13] ^ cur_lf[12] ^ cur_lf[10]};

  wire [5:0] widx = cur_ph[PHASE_W-1 -: 6];
  wire [3:0] qidx = widx[4] ? ~widx[3:0] : widx[3:0];
  logic [6:0] mag;

  always_comb begin
    case (qidx)
      4'd0:  mag = 7'd6;
      4'd1:  mag = 7'd19;
      4'd2:  mag = 7'd31;
      4'd3:  mag = 7'd43;
      4'd4:  mag = 7'd54;
      4'd5:  mag = 7'd65;
      4'd6:  mag = 7'd76;
      4'd7:  mag = 7'd85;
      4'd8:  mag = 7'd94;
      4'd9:  mag = 7'd102;
      4'd10: mag = 7'd109;
      4'd11: mag = 7'd115;
      4'd12: mag = 7'd120;
      4'd13: mag = 7'd123;
      4'd14: mag = 7'd126;
      default: mag = 7'd127;
    endcase
  end

  wire signed [7:0]  sine_s = widx[5] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  wire signed [7:0]  wave_s = cur[15] ? $signed(cur_lf[15:8]) : sine_s;
  wire signed [16:0] prod_l = wave_s * $signed({1'b0, cur[23:16]});
  wire signed [16:0] prod_r = wave_s * $signed({1'b0, cur[31:24]});

  wire signed [ACC_W-1:0] nxt_l = acc_l_q + ACC_W'(prod_l);
  wire signed [ACC_W-1:0] nxt_r = acc_r_q + ACC_W'(prod_r);
  wire signed [MIX_W-1:0] mix_l = MIX_W'(nxt_l >>> FRAC_SH) + MIX_W'($signed(smp_l) >>> FRAC_SH);
  wire signed [MIX_W-1:0] mix_r = MIX_W'(nxt_r >>> FRAC_SH) + MIX_W'($signed(smp_r) >>> FRAC_SH);

  function automatic logic [OUT_W-1:0] clamp(input logic signed [MIX_W-1:0] v);
    if (v > HI)      return HI[OUT_W-1:0];
    else if (v < LO) return LO[OUT_W-1:0];
    else             return v[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_l     <= '0;
      out_r     <= '0;
      idx_q     <= '0;
      acc_l_q   <= '0;
      acc_r_q   <= '0;
      for (int v = 0; v < NVOICE; v++) begin
        voice_q[v] <= '0;
        phase_q[v] <= '0;
        lfsr_q[v]  <= LFSR_SEED;
      end
    end else begin
      out_valid <= 1'b0;
      if (wr_en) voice_q[wr_addr] <= wr_data;
      if (!busy && tick) begin
        busy    <= 1'b1;
        idx_q   <= '0;
        acc_l_q <= '0;
        acc_r_q <= '0;
      end else if (busy) begin
        phase_q[idx_q] <= ph_sum[PHASE_W-1:0];
        if (ph_sum[PHASE_W]) lfsr_q[idx_q] <= lf_step;
        if (idx_q == LAST) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_l     <= clamp(mix_l);
          out_r     <= clamp(mix_r);
        end else begin
          idx_q   <= idx_q + 1'b1;
          acc_l_q <= nxt_l;
          acc_r_q <= nxt_r;
        end
      end
    end
  end

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy && $past(busy) && $past(idx_q) == LAST);

  // R3
  sweep_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tick) && idx_q == '0);

  // R4
  tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx_q != LAST) |=> busy && idx_q == $past(idx_q) + 1'b1);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_l) && $stable(out_r));
endmodule

// File: tb/voice_synth_bench.sv
module voice_synth_bench;
  localparam int PW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] smp_l = '0, smp_r = '0;
  logic busy, out_valid;
  logic [11:0] out_l, out_r;

  always #2 clk = ~clk;

  voice_synth u_voice_synth (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .smp_l(smp_l), .smp_r(smp_r), .busy(busy),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r));

  int checks = 0, errors = 0;
  logic [31:0] m_reg [64];
  int          m_ph  [64];
  logic [15:0] m_lf  [64];
  int exp_l, exp_r, raw_l, raw_r;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sine_val(input int k);
    real r;
    r = 127.0 * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 64.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    else return -$rtoi(-r + 0.5);
  endfunction

  function automatic int sat12(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic logic [15:0] lf_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic model_sweep();
    int al = 0, ar = 0;
    for (int v = 0; v < 64; v++) begin
      int s, nph;
      s = m_reg[v][15] ? int'($signed(m_lf[v][15:8])) : sine_val(m_ph[v] >> (PW - 6));
      al += s * int'(m_reg[v][23:16]);
      ar += s * int'(m_reg[v][31:24]);
      nph = m_ph[v] + int'(m_reg[v][14:0]);
      if (nph >= (1 << PW)) begin
        nph -= (1 << PW);
        m_lf[v] = lf_next(m_lf[v]);
      end
      m_ph[v] = nph;
    end
    raw_l = (al >>> 4) + (int'($signed(smp_l)) >>> 4);
    raw_r = (ar >>> 4) + (int'($signed(smp_r)) >>> 4);
    exp_l = sat12(raw_l);
    exp_r = sat12(raw_r);
  endtask

  task automatic write_voice(input int v, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'(v); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_reg[v] = d;
  endtask

  task automatic clear_all();
    for (int v = 0; v < 64; v++) write_voice(v, 32'h0);
  endtask

  task automatic run_sweep(input string tag, input bit extra);
    logic [11:0] pl, pr;
    int bad = 0, hold_bad = 0;
    model_sweep();
    pl = out_l; pr = out_r;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (!busy || out_valid) bad++;
    for (int i = 1; i < 64; i++) begin
      @(negedge clk);
      if (!busy || out_valid) bad++;
      if (out_l !== pl || out_r !== pr) hold_bad++;
      if (extra && i == 10) tick = 1'b1;
      if (extra && i == 11) tick = 1'b0;
    end
    @(negedge clk);
    if (!out_valid || busy) bad++;
    chk({tag, " R10 hold between strobes"}, hold_bad, 0);
    chk({tag, " left (R8)"}, int'($signed(out_l)), exp_l);
    chk({tag, " right (R8)"}, int'($signed(out_r)), exp_r);
    @(negedge clk);
    if (out_valid) bad++;
    chk({tag, extra ? " R4 late tick timing" : " R3 sweep timing"}, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int v = 0; v < 64; v++) begin
      m_reg[v] = '0; m_ph[v] = 0; m_lf[v] = 16'hACE1;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_l", int'(out_l), 0);
    chk("R1 out_r", int'(out_r), 0);

    // R1: control words all zero, only the sample passes
    smp_l = 16'h7FF0; smp_r = 16'h8000;
    run_sweep("R1 silent voices", 1'b0);
    chk("R1 R8 sample-only left", int'($signed(out_l)), 2047);
    chk("R1 R8 sample-only right", int'($signed(out_r)), -2048);

    // R8 positive rail: phase 0, sine value 6 in every voice
    smp_l = '0; smp_r = 16'h8000;
    for (int v = 0; v < 64; v++) write_voice(v, 32'hFFFF_0000);
    run_sweep("R8 top rail", 1'b0);
    chk("R8 top rail left", int'($signed(out_l)), 2047);
    chk("R8 top rail right", int'($signed(out_r)), 2047);

    // R7 R8 negative rail: seed top byte 0xAC is -84 in every voice
    smp_l = '0; smp_r = '0;
    for (int v = 0; v < 64; v++) write_voice(v, 32'hFFFF_8000);
    run_sweep("R7 seed noise", 1'b0);
    chk("R7 R8 bottom rail left", int'($signed(out_l)), -2048);
    chk("R7 R8 bottom rail right", int'($signed(out_r)), -2048);

    // R2 R5 R6: one sine voice stepping one table index per sweep
    clear_all();
    write_voice(5, {8'd16, 8'd160, 1'b0, 15'd16384});
    for (int n = 0; n < 70; n++) run_sweep("R2 R5 R6 sine walk", 1'b0);

    // R7: noise voice, steps its register on phase wraps
    clear_all();
    write_voice(9, {8'd100, 8'd200, 1'b1, 15'd32767});
    for (int n = 0; n < 40; n++) run_sweep("R7 noise wrap", 1'b0);

    // R4: tick in the middle of a sweep
    write_voice(20, {8'd50, 8'd90, 1'b0, 15'd12345});
    for (int n = 0; n < 5; n++) run_sweep("R4", 1'b1);

    // R9: amplitude sums within 255, no sample
    for (int v = 0; v < 64; v++)
      write_voice(v, {6'd0, 2'($urandom), 6'd0, 2'($urandom), 1'($urandom), 15'($urandom)});
    for (int n = 0; n < 20; n++) begin
      run_sweep("R9 no clip", 1'b0);
      chk("R9 left inside range", int'(raw_l <= 2047 && raw_l >= -2048), 1);
      chk("R9 right inside range", int'(raw_r <= 2047 && raw_r >= -2048), 1);
    end

    // R8: random mixes with samples, rewrites between sweeps
    for (int n = 0; n < 40; n++) begin
      for (int j = 0; j < 4; j++) write_voice(int'($urandom % 64), $urandom);
      smp_l = 16'($urandom); smp_r = 16'($urandom);
      run_sweep("R8 random mix", 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule